// File: doc/BRIEF.md
# Exception Vector Entry Unit

This unit turns an exception request into the address the core fetches next and the status word it loads on entry. Each request carries an exception index and the current status and configuration words. The offset is the index moved up by eight bit positions. When the configuration word says a programmable base exists, the base register value is ORed in. When the status word asks for high-memory vectors, a fixed high prefix is also ORed in.

The vector is registered. It appears, together with a one-cycle redirect strobe, on the cycle after the request. On entry the new status word has supervisor mode set. Interrupt enable, tick-timer enable and both address-translation enables are cleared. Two strobes go out with the redirect: one turns off translation and one drops any atomic reservation. An index of zero, or one at or above the supported count, produces an error pulse in place of a redirect and leaves the vector output unchanged.

The unit also holds the vector base register, which is read and written through the special-register port. The same port answers two fixed identity reads: the core number and the number of cores.

Top module: `exc_vector_entry`

## Requirements
- R1: While reset is held and after it is released, the redirect, error and strobe outputs are 0, the vector and status outputs are 0, and the base register reads 0.
- R2: A legal request (index 1 to NUM_EXC-1, default 1 to 14) raises redirect for exactly one cycle, on the cycle after the request. The vector output then holds index*256 when neither the base nor the prefix applies.
- R3: When bit 12 of the configuration input is 1, the base register value is ORed into the vector; when bit 12 is 0, the base is not used.
- R4: When bit 14 of the status input is 1, 0xF000_0000 is ORed into the vector.
- R5: The status output loaded on a legal request equals the status input with bit 0 (supervisor) set and bits 1 (tick enable), 2 (interrupt enable), 5 (data translation) and 6 (instruction translation) cleared. Every other bit is kept.
- R6: The translation-off strobe and the reservation-clear strobe pulse in exactly the cycles where redirect is high.
- R7: An index of 0, or an index of NUM_EXC or more, raises the error output for one cycle on the cycle after the request. Redirect stays low, and the vector and status outputs keep their previous values.
- R8: A write at special-register address 11 (group 0, index 11) loads the base register, and a read at that address returns it. Writes to any other address leave it unchanged.
- R9: A read at address 128 returns 0 (core number), and a read at address 129 returns 1 (core count). The hit output is 1 for addresses 11, 128 and 129 and 0 for all others, which read as 0.
- R10: When a base write and a request fall in the same cycle, the vector uses the base value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | Exception request, one cycle per request |
| exc_idx_i | input | 5 | Exception index |
| status_i | input | 32 | Current status word |
| config_i | input | 32 | CPU configuration word (bit 12 = base present) |
| spr_we_i | input | 1 | Special-register write enable |
| spr_addr_i | input | 16 | Special-register address, group in [15:11] |
| spr_wdata_i | input | 32 | Special-register write data |
| spr_rdata_o | output | 32 | Special-register read data (combinational) |
| spr_hit_o | output | 1 | Address belongs to this unit |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| vec_addr_o | output | 32 | Vector fetch address |
| status_o | output | 32 | Status word to load on entry |
| xlat_off_o | output | 1 | Address translation disable strobe |
| resv_clr_o | output | 1 | Atomic reservation clear strobe |
| illegal_o | output | 1 | Illegal index error pulse |

## Verification
The assertions assume that `exc_req_i` is a single-cycle pulse, with at least one idle cycle between requests. They also assume that the index, status and configuration inputs are stable in the cycle the request is sampled. Under those conditions a redirect is always preceded by a request, and redirect and error never overlap. The stimulus raises each request for one cycle and drops it again. All inputs change on the falling clock edge, away from the sampling edge. Each scenario then waits for the outputs to settle before the next one starts, so these conditions always hold.

// File: rtl/evu_pkg.sv
package evu_pkg;
   // status word bit positions, decoded by the rest of the core
   localparam int unsigned ST_SUPER    = 0;
   localparam int unsigned ST_TICK_EN  = 1;
   localparam int unsigned ST_IRQ_EN   = 2;
   localparam int unsigned ST_DXLAT_EN = 5;
   localparam int unsigned ST_IXLAT_EN = 6;
   localparam int unsigned ST_HI_VEC   = 14;
   // configuration word: base register present
   localparam int unsigned CFG_BASE_PRESENT = 12;
   // special-register addressing: group in upper bits, index below
   localparam int unsigned SPR_IDX_W = 11;

   function automatic logic [15:0] spr_at(input int unsigned grp, input int unsigned idx);
      return 16'((grp << SPR_IDX_W) + idx);
   endfunction

   localparam logic [15:0] SPR_VBASE  = spr_at(0, 11);
   localparam logic [15:0] SPR_COREID = spr_at(0, 128);
   localparam logic [15:0] SPR_NCORES = spr_at(0, 129);
endpackage

// File: rtl/evu_spr_regs.sv
module evu_spr_regs
   import evu_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned SPR_AW = 16,
   parameter int unsigned N_CORES = 1,
   parameter int unsigned CORE_NUM = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [SPR_AW-1:0] addr_i,
   input  logic [XLEN-1:0]   wdata_i,
   output logic [XLEN-1:0]   base_o,
   output logic [XLEN-1:0]   rdata_o,
   output logic              hit_o
);
   localparam logic [SPR_AW-1:0] A_BASE = SPR_AW'(SPR_VBASE);
   localparam logic [SPR_AW-1:0] A_CID  = SPR_AW'(SPR_COREID);
   localparam logic [SPR_AW-1:0] A_NCR  = SPR_AW'(SPR_NCORES);

   if (SPR_AW < 16) begin : g_bad_aw
      $error("evu_spr_regs: SPR_AW must be at least 16");
   end

   logic [XLEN-1:0] base_q;
   logic            base_wr;

   assign base_wr = we_i && (addr_i == A_BASE);

   always_ff @(posedge clk) begin
      if (!rst_n) base_q <= '0;
      else if (base_wr) base_q <= wdata_i;
   end

   assign base_o = base_q;

   always_comb begin
      rdata_o = '0;
      hit_o   = 1'b1;
      unique case (addr_i)
         A_BASE:  rdata_o = base_q;
         A_CID:   rdata_o = XLEN'(CORE_NUM);
         A_NCR:   rdata_o = XLEN'(N_CORES);
         default: hit_o   = 1'b0;
      endcase
   end

   // R8: a base write is visible on the next cycle
   assert_base_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && addr_i == A_BASE) |=> (base_o == $past(wdata_i)));

   // R8: no write to the base address leaves the base unchanged
   assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && addr_i == A_BASE) |=> $stable(base_o));
endmodule

// File: rtl/evu_vec_calc.sv
module evu_vec_calc
   import evu_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned NUM_EXC   = 15,
   parameter int unsigned OFS_SHIFT = 8,
   parameter bit          HI_EN     = 1'b1,
   parameter logic [31:0] HI_PREFIX = 32'hF000_0000
) (
   input  logic [IDX_W-1:0] idx_i,
   input  logic [XLEN-1:0]  base_i,
   input  logic [XLEN-1:0]  cfg_i,
   input  logic [XLEN-1:0]  st_i,
   output logic [XLEN-1:0]  vec_o,
   output logic             legal_o
);
   localparam int unsigned PAD_W = XLEN - IDX_W - OFS_SHIFT;

   if (XLEN < IDX_W + OFS_SHIFT + 1) begin : g_bad_w
      $error("evu_vec_calc: XLEN too small for index and shift");
   end
   if (NUM_EXC > (1 << IDX_W)) begin : g_bad_n
      $error("evu_vec_calc: NUM_EXC exceeds index range");
   end

   logic [XLEN-1:0] ofs;
   logic [XLEN-1:0] base_part;
   logic [XLEN-1:0] hi_part;

   assign ofs = {{PAD_W{1'b0}}, idx_i, {OFS_SHIFT{1'b0}}};
   assign base_part = cfg_i[CFG_BASE_PRESENT] ? base_i : '0;

   if (HI_EN) begin : g_hi
      assign hi_part = st_i[ST_HI_VEC] ? XLEN'(HI_PREFIX) : '0;
   end else begin : g_no_hi
      assign hi_part = '0;
   end

   assign vec_o   = ofs | base_part | hi_part;
   assign legal_o = (idx_i != '0) && (32'(idx_i) < NUM_EXC);
endmodule

// File: rtl/evu_status_upd.sv
module evu_status_upd
   import evu_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [XLEN-1:0] st_i,
   output logic [XLEN-1:0] st_o,
   output logic            xlat_off_o,
   output logic            resv_clr_o
);
   localparam logic [XLEN-1:0] CLR_MASK =
      (XLEN'(1) << ST_TICK_EN) | (XLEN'(1) << ST_IRQ_EN) |
      (XLEN'(1) << ST_DXLAT_EN) | (XLEN'(1) << ST_IXLAT_EN);
   localparam logic [XLEN-1:0] SET_MASK = XLEN'(1) << ST_SUPER;

   if (XLEN <= ST_HI_VEC) begin : g_bad_w
      $error("evu_status_upd: XLEN too narrow for status bits");
   end

   logic [XLEN-1:0] st_q;
   logic            off_q;
   logic            clr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= '0;
         off_q <= 1'b0;
         clr_q <= 1'b0;
      end else begin
         off_q <= load_i;
         clr_q <= load_i;
         if (load_i) st_q <= (st_i & ~CLR_MASK) | SET_MASK;
      end
   end

   assign st_o       = st_q;
   assign xlat_off_o = off_q;
   assign resv_clr_o = clr_q;

   // R5: after a load, supervisor set and enables cleared
   assert_entry_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (st_o[ST_SUPER] && !st_o[ST_IRQ_EN] && !st_o[ST_TICK_EN]
                  && !st_o[ST_DXLAT_EN] && !st_o[ST_IXLAT_EN]));

   // R5: untouched bits are carried through
   assert_keep_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ((st_o & ~(CLR_MASK | SET_MASK)) == ($past(st_i) & ~(CLR_MASK | SET_MASK))));
endmodule

// File: rtl/exc_vector_entry.sv
module exc_vector_entry
   import evu_pkg::*;
#(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned NUM_EXC   = 15,
   parameter int unsigned SPR_AW    = 16,
   parameter bit          HI_EN     = 1'b1,
   parameter logic [31:0] HI_PREFIX = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_req_i,
   input  logic [IDX_W-1:0]  exc_idx_i,
   input  logic [XLEN-1:0]   status_i,
   input  logic [XLEN-1:0]   config_i,
   input  logic              spr_we_i,
   input  logic [SPR_AW-1:0] spr_addr_i,
   input  logic [XLEN-1:0]   spr_wdata_i,
   output logic [XLEN-1:0]   spr_rdata_o,
   output logic              spr_hit_o,
   output logic              redirect_o,
   output logic [XLEN-1:0]   vec_addr_o,
   output logic [XLEN-1:0]   status_o,
   output logic              xlat_off_o,
   output logic              resv_clr_o,
   output logic              illegal_o
);
   if (NUM_EXC < 2) begin : g_bad_n
      $error("exc_vector_entry: NUM_EXC must allow at least one legal index");
   end

   logic [XLEN-1:0] base;
   logic [XLEN-1:0] vec_next;
   logic            legal;
   logic            take;
   logic            reject;

   evu_spr_regs #(.XLEN(XLEN), .SPR_AW(SPR_AW), .N_CORES(1), .CORE_NUM(0)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (spr_we_i),
      .addr_i  (spr_addr_i),
      .wdata_i (spr_wdata_i),
      .base_o  (base),
      .rdata_o (spr_rdata_o),
      .hit_o   (spr_hit_o)
   );

   evu_vec_calc #(.XLEN(XLEN), .IDX_W(IDX_W), .NUM_EXC(NUM_EXC), .OFS_SHIFT(8),
                  .HI_EN(HI_EN), .HI_PREFIX(HI_PREFIX)) u_calc (
      .idx_i   (exc_idx_i),
      .base_i  (base),
      .cfg_i   (config_i),
      .st_i    (status_i),
      .vec_o   (vec_next),
      .legal_o (legal)
   );

   assign take   = exc_req_i && legal;
   assign reject = exc_req_i && !legal;

   evu_status_upd #(.XLEN(XLEN)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (take),
      .st_i       (status_i),
      .st_o       (status_o),
      .xlat_off_o (xlat_off_o),
      .resv_clr_o (resv_clr_o)
   );

   logic            redir_q;
   logic            err_q;
   logic [XLEN-1:0] vec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         redir_q <= 1'b0;
         err_q   <= 1'b0;
         vec_q   <= '0;
      end else begin
         redir_q <= take;
         err_q   <= reject;
         if (take) vec_q <= vec_next;
      end
   end

   assign redirect_o = redir_q;
   assign illegal_o  = err_q;
   assign vec_addr_o = vec_q;

   // R2: every redirect follows a request one cycle earlier
   assert_redirect_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> $past(exc_req_i));

   // R2: vector offset bits carry the index
   assert_vec_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (vec_addr_o[IDX_W+7:8] & $past(exc_idx_i)) == $past(exc_idx_i));

   // R6: side strobes coincide with redirect
   assert_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_off_o == redirect_o) && (resv_clr_o == redirect_o));

   // R7: error and redirect never overlap
   assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(illegal_o && redirect_o));

   // R7: a rejected request leaves the vector in place
   assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> $stable(vec_addr_o));

   // R4: high-vector requests land in the prefixed region
   assert_hi_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && status_i[ST_HI_VEC] && HI_EN) |=> ((vec_addr_o & XLEN'(HI_PREFIX)) == XLEN'(HI_PREFIX)));
endmodule

// File: tb/test_exc_vector_entry.sv
module test_exc_vector_entry;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        exc_req_i;
   logic [4:0]  exc_idx_i;
   logic [31:0] status_i;
   logic [31:0] config_i;
   logic        spr_we_i;
   logic [15:0] spr_addr_i;
   logic [31:0] spr_wdata_i;
   logic [31:0] spr_rdata_o;
   logic        spr_hit_o;
   logic        redirect_o;
   logic [31:0] vec_addr_o;
   logic [31:0] status_o;
   logic        xlat_off_o;
   logic        resv_clr_o;
   logic        illegal_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   exc_vector_entry i_exc_vector_entry (
      .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .exc_idx_i(exc_idx_i),
      .status_i(status_i), .config_i(config_i), .spr_we_i(spr_we_i),
      .spr_addr_i(spr_addr_i), .spr_wdata_i(spr_wdata_i),
      .spr_rdata_o(spr_rdata_o), .spr_hit_o(spr_hit_o),
      .redirect_o(redirect_o), .vec_addr_o(vec_addr_o), .status_o(status_o),
      .xlat_off_o(xlat_off_o), .resv_clr_o(resv_clr_o), .illegal_o(illegal_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] entry_status(input logic [31:0] s);
      return (s & ~32'h0000_0066) | 32'h1;
   endfunction

   task automatic spr_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      spr_we_i = 1'b1; spr_addr_i = a; spr_wdata_i = d;
      @(negedge clk);
      spr_we_i = 1'b0;
   endtask

   task automatic spr_read(input logic [15:0] a, output logic [31:0] d, output logic h);
      spr_addr_i = a;
      #1;
      d = spr_rdata_o; h = spr_hit_o;
   endtask

   // legal request: strobe next cycle, gone the cycle after
   task automatic t_request(input string req, input logic [4:0] idx,
                            input logic [31:0] st, input logic [31:0] cfg,
                            input logic [31:0] exp_vec);
      @(negedge clk);
      exc_req_i = 1'b1; exc_idx_i = idx; status_i = st; config_i = cfg;
      @(negedge clk);
      exc_req_i = 1'b0;
      check(req, "redirect", {31'b0, redirect_o}, 32'd1);
      check(req, "vector", vec_addr_o, exp_vec);
      check("R5", "status", status_o, entry_status(st));
      check("R6", "xlat_off", {31'b0, xlat_off_o}, 32'd1);
      check("R6", "resv_clr", {31'b0, resv_clr_o}, 32'd1);
      check("R7", "no error on legal", {31'b0, illegal_o}, 32'd0);
      @(negedge clk);
      check("R2", "redirect one cycle", {31'b0, redirect_o}, 32'd0);
      check("R6", "strobes drop", {30'b0, xlat_off_o, resv_clr_o}, 32'd0);
   endtask

   task automatic t_illegal(input logic [4:0] idx);
      logic [31:0] v0, s0;
      v0 = vec_addr_o; s0 = status_o;
      @(negedge clk);
      exc_req_i = 1'b1; exc_idx_i = idx; status_i = 32'h0000_4000; config_i = 32'h1000;
      @(negedge clk);
      exc_req_i = 1'b0;
      check("R7", "error", {31'b0, illegal_o}, 32'd1);
      check("R7", "no redirect", {31'b0, redirect_o}, 32'd0);
      check("R7", "vector kept", vec_addr_o, v0);
      check("R7", "status kept", status_o, s0);
      @(negedge clk);
      check("R7", "error one cycle", {31'b0, illegal_o}, 32'd0);
   endtask

   task automatic t_reset;
      logic [31:0] d; logic h;
      rst_n = 1'b0; exc_req_i = 1'b0; exc_idx_i = '0; status_i = '0; config_i = '0;
      spr_we_i = 1'b0; spr_addr_i = '0; spr_wdata_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "outputs", {26'b0, redirect_o, illegal_o, xlat_off_o, resv_clr_o, 2'b0}, 32'd0);
      check("R1", "vector", vec_addr_o, 32'd0);
      check("R1", "status", status_o, 32'd0);
      spr_read(16'd11, d, h);
      check("R1", "base", d, 32'd0);
   endtask

   task automatic t_spr;
      logic [31:0] d; logic h;
      spr_write(16'd11, 32'h0001_2300);
      spr_read(16'd11, d, h);
      check("R8", "base read", d, 32'h0001_2300);
      check("R9", "base hit", {31'b0, h}, 32'd1);
      spr_write(16'd12, 32'hDEAD_0000);
      spr_write(16'd128, 32'h5555_0000);
      spr_write(16'h080B, 32'h7777_0000);
      spr_read(16'd11, d, h);
      check("R8", "base unchanged by other writes", d, 32'h0001_2300);
      spr_read(16'd128, d, h);
      check("R9", "core number", d, 32'd0);
      check("R9", "core number hit", {31'b0, h}, 32'd1);
      spr_read(16'd129, d, h);
      check("R9", "core count", d, 32'd1);
      check("R9", "core count hit", {31'b0, h}, 32'd1);
      spr_read(16'd12, d, h);
      check("R9", "miss data", d, 32'd0);
      check("R9", "miss hit", {31'b0, h}, 32'd0);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      spr_we_i = 1'b1; spr_addr_i = 16'd11; spr_wdata_i = 32'h0004_0000;
      exc_req_i = 1'b1; exc_idx_i = 5'd3; status_i = 32'h0; config_i = 32'h1000;
      @(negedge clk);
      spr_we_i = 1'b0; exc_req_i = 1'b0;
      check("R10", "old base used", vec_addr_o, 32'h0001_2300);
      check("R10", "redirect", {31'b0, redirect_o}, 32'd1);
      @(negedge clk);
      t_request("R10", 5'd3, 32'h0, 32'h1000, 32'h0004_0300);
   endtask

   initial begin
      t_reset();
      t_request("R2", 5'd1, 32'h0000_0000, 32'h0, 32'h0000_0100);
      t_request("R2", 5'd14, 32'h0000_0067, 32'h0, 32'h0000_0E00);
      t_spr();
      t_request("R3", 5'd2, 32'h0000_0024, 32'h0000_1000, 32'h0001_2300);
      t_request("R3", 5'd2, 32'h0000_0024, 32'hFFFF_EFFF, 32'h0000_0200);
      t_request("R4", 5'd5, 32'h0000_4000, 32'h0, 32'hF000_0500);
      t_request("R4", 5'd7, 32'hFFFF_FFFF, 32'h0000_1000, 32'hF001_2700);
      t_illegal(5'd0);
      t_illegal(5'd15);
      t_illegal(5'd31);
      t_same_cycle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule